// File: doc/BRIEF.md
# CAN Bit Time Quantum Sequencer

This block divides the system clock into CAN time quanta and walks each nominal bit through its segments: sync, propagation, phase 1 and phase 2. It reports the quantum tick, a strobe at the sampling point, a strobe at the bit boundary and the segment currently in progress. A bit-level protocol engine uses the sample strobe to latch the bus level and the boundary strobe to move on to the next bit.

All timing comes from one packed timing word. Each segment length and the prescaler are stored as the count minus one. The word is captured only while the configuration input is held high. While that input is high, the sequencer is parked in the sync segment.

Two inputs realign the bit to the bus. A hard-sync pulse restarts the bit from the beginning. A falling bus edge, from recessive to dominant, causes a bounded phase correction: an edge that arrives late stretches phase 1, and an edge that arrives early cuts phase 2 short. The correction is never more than the resync jump width plus one quantum.

Top module: `cbt_sequencer`

## Requirements
- R1: While running, `tq_tick` is high for one clock in every P+1 clocks, where P is the prescaler code (0..255). After the configuration input or a hard-sync pulse is released, the first tick appears in the (P+1)-th clock, counting the release cycle as the first.
- R2: Timing word layout: bits [7:0] hold the prescaler code, [10:8] the propagation code A, [13:11] the phase-1 code B, [16:14] the phase-2 code C and [18:17] the jump-width code J. With no correction, a bit lasts 1 + (A+1) + (B+1) + (C+1) quanta.
- R3: `sample_stb` is high for exactly one clock per bit. It coincides with the tick that ends phase 1, which is quantum index A+B+2 counted from 0 at the sync quantum.
- R4: `bit_stb` is high for one clock and coincides with the tick that ends phase 2, the last quantum of the bit. The next quantum is a sync quantum.
- R5: A phase-2 code of 0 is treated as 1, so phase 2 is never shorter than 2 quanta.
- R6: `seg` reports the segment of the current quantum: 0 for sync, 1 for propagation, 2 for phase 1, 3 for phase 2.
- R7: A falling `rx` edge seen during propagation or phase 1 lengthens phase 1 by min(E, J+1). E is the number of quanta of time segment 1 already completed when the edge is seen, so an edge in the first propagation quantum gives no change.
- R8: A falling `rx` edge seen during phase 2 shortens phase 2 by min(R, J+1). R is the number of phase-2 quanta still left after the current one. The correction applies only to the bit in which the edge was seen.
- R9: A falling edge during the sync quantum has no effect, and a rising `rx` edge never has an effect.
- R10: A `hard_sync` pulse clears the quantum and prescaler counters and places the block in the sync segment. The first tick after the pulse ends that sync quantum, and a full bit follows.
- R11: While `cfg_mode` is high, there is no tick and no strobe, and `seg` is 0. Changes to `cfg_word` while `cfg_mode` is low have no effect.
- R12: After reset, with `cfg_mode` high, all strobes are low and `seg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Holds the sequencer idle and captures `cfg_word` |
| cfg_word | input | 19 | Packed timing word (layout in R2) |
| rx | input | 1 | Bus level; 1 = recessive, 0 = dominant |
| hard_sync | input | 1 | Restarts the bit at the sync segment |
| tq_tick | output | 1 | Time-quantum tick |
| sample_stb | output | 1 | Sample-point strobe |
| bit_stb | output | 1 | Bit-boundary strobe |
| seg | output | 2 | Current segment (encoding in R6) |

## Verification
The prescaler is driven with three settings: single-clock quanta, a divide-by-4 case and the largest 256-clock quantum. Together they separate an off-by-one in the tick period from a mishandled code. Segment sets at the minimum, a mixed middle case and the all-maximum case check that each field is placed in the word correctly and that the sample point lands where the codes predict. Falling edges are injected in the sync quantum, in the first propagation quantum, later in time segment 1 and in phase 2, with two jump widths. These show the ignored case, the zero-error case, the error-limited correction and the jump-width-limited correction, and they confirm that a correction does not carry into the next bit. A hard sync in mid-bit and a word change outside configuration mode complete the set.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

   localparam int unsigned CBT_PRESC_W = 8;
   localparam int unsigned CBT_SEG_W   = 3;
   localparam int unsigned CBT_RJW_W   = 2;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;

endpackage

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
   parameter int unsigned PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic [PRESC_W-1:0] div_i,
   output logic               tick_o
);

   logic [PRESC_W-1:0] cnt_q;

   assign tick_o = !clr_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && (div_i != '0) && !clr_i) |=> !tick_o); // R1

endmodule

// File: rtl/cbt_edge_detect.sv
module cbt_edge_detect #(
   parameter int unsigned RX_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic fall_o
);

   logic rx_s;
   logic rx_prev_q;

   generate
      if (RX_SYNC == 0) begin : g_direct
         assign rx_s = rx_i;
      end else begin : g_sync
         logic [RX_SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= rx_i;
               for (int i = 1; i < RX_SYNC; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign rx_s = sh_q[RX_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev_q <= 1'b1;
      else        rx_prev_q <= rx_s;
   end

   assign fall_o = rx_prev_q && !rx_s;

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
   import cbt_pkg::*;
#(
   parameter int unsigned SEG_W = 3,
   parameter int unsigned RJW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             fall_i,
   input  logic [SEG_W-1:0] prop_i,
   input  logic [SEG_W-1:0] ph1_i,
   input  logic [SEG_W-1:0] ph2_i,
   input  logic [RJW_W-1:0] rjw_i,
   output seg_e             seg_o,
   output logic             sample_o,
   output logic             bit_o
);

   localparam int unsigned QW = SEG_W + 1;
   localparam int unsigned PW = SEG_W + 2;
   localparam int unsigned AW = RJW_W + 1;

   seg_e            seg_q;
   logic [QW-1:0]   qcnt_q;
   logic [AW-1:0]   ext_q, shr_q;

   logic [SEG_W-1:0] ph2_eff;
   logic [AW-1:0]    lim;
   logic [PW-1:0]    pos1;
   logic [QW-1:0]    rem2;
   logic             in_t1, in_p2;
   logic [AW-1:0]    ext_new, shr_new, ext_eff, shr_eff;
   logic [QW-1:0]    end1, end2;
   logic             last;

   assign ph2_eff = (ph2_i == '0) ? SEG_W'(1) : ph2_i;
   assign lim     = AW'(rjw_i) + AW'(1);
   assign in_t1   = (seg_q == SEG_PROP) || (seg_q == SEG_PH1);
   assign in_p2   = (seg_q == SEG_PH2);

   // quanta of time segment 1 already completed
   assign pos1 = (seg_q == SEG_PROP) ? PW'(qcnt_q)
                                     : PW'(prop_i) + PW'(1) + PW'(qcnt_q);
   // phase 2 quanta left after the current one
   assign rem2 = QW'(ph2_eff) - qcnt_q;

   assign ext_new = (pos1 < PW'(lim)) ? AW'(pos1) : lim;
   assign shr_new = (rem2 < QW'(lim)) ? AW'(rem2) : lim;
   assign ext_eff = (fall_i && in_t1) ? ext_new : ext_q;
   assign shr_eff = (fall_i && in_p2) ? shr_new : shr_q;

   assign end1 = QW'(ph1_i) + QW'(ext_eff);
   assign end2 = QW'(ph2_eff) - QW'(shr_eff);

   always_comb begin
      unique case (seg_q)
         SEG_SYNC: last = 1'b1;
         SEG_PROP: last = (qcnt_q == QW'(prop_i));
         SEG_PH1:  last = (qcnt_q == end1);
         default:  last = (qcnt_q == end2);
      endcase
   end

   assign sample_o = tick_i && last && (seg_q == SEG_PH1);
   assign bit_o    = tick_i && last && (seg_q == SEG_PH2);
   assign seg_o    = seg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q  <= SEG_SYNC;
         qcnt_q <= '0;
         ext_q  <= '0;
         shr_q  <= '0;
      end else if (clr_i) begin
         seg_q  <= SEG_SYNC;
         qcnt_q <= '0;
         ext_q  <= '0;
         shr_q  <= '0;
      end else begin
         if (fall_i && in_t1) ext_q <= ext_new;
         if (fall_i && in_p2) shr_q <= shr_new;
         if (tick_i) begin
            if (last) begin
               qcnt_q <= '0;
               unique case (seg_q)
                  SEG_SYNC: seg_q <= SEG_PROP;
                  SEG_PROP: seg_q <= SEG_PH1;
                  SEG_PH1:  seg_q <= SEG_PH2;
                  default: begin
                     seg_q <= SEG_SYNC;
                     ext_q <= '0;
                     shr_q <= '0;
                  end
               endcase
            end else begin
               qcnt_q <= qcnt_q + 1'b1;
            end
         end
      end
   end

   AST_SAMPLE_TO_PH2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |=> (seg_q == SEG_PH2)); // R3

   AST_BIT_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      bit_o |=> (seg_q == SEG_SYNC)); // R4

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(seg_q)); // R6

   AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
      (ext_q <= lim) && (shr_q <= lim)); // R7

endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer
   import cbt_pkg::*;
#(
   parameter int unsigned PRESC_W = CBT_PRESC_W,
   parameter int unsigned SEG_W   = CBT_SEG_W,
   parameter int unsigned RJW_W   = CBT_RJW_W,
   parameter int unsigned RX_SYNC = 0,
   localparam int unsigned CFG_W  = PRESC_W + 3 * SEG_W + RJW_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mode,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             rx,
   input  logic             hard_sync,
   output logic             tq_tick,
   output logic             sample_stb,
   output logic             bit_stb,
   output logic [1:0]       seg
);

   localparam int unsigned OFS_PROP = PRESC_W;
   localparam int unsigned OFS_PH1  = PRESC_W + SEG_W;
   localparam int unsigned OFS_PH2  = PRESC_W + 2 * SEG_W;
   localparam int unsigned OFS_RJW  = PRESC_W + 3 * SEG_W;

   generate
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc
         $error("cbt_sequencer: PRESC_W out of range");
      end
      if (SEG_W < 2 || SEG_W > 6) begin : g_bad_seg
         $error("cbt_sequencer: SEG_W out of range");
      end
      if (RJW_W < 1 || RJW_W > SEG_W) begin : g_bad_rjw
         $error("cbt_sequencer: RJW_W must be 1..SEG_W");
      end
      if (RX_SYNC > 3) begin : g_bad_sync
         $error("cbt_sequencer: RX_SYNC must be 0..3");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic             clr;
   logic             fall;
   seg_e             seg_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (cfg_mode) cfg_q <= cfg_word;
   end

   assign clr = cfg_mode || hard_sync;

   cbt_tq_prescaler #(.PRESC_W(PRESC_W)) i_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .div_i  (cfg_q[PRESC_W-1:0]),
      .tick_o (tq_tick)
   );

   cbt_edge_detect #(.RX_SYNC(RX_SYNC)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx),
      .fall_o (fall)
   );

   cbt_seg_fsm #(.SEG_W(SEG_W), .RJW_W(RJW_W)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .tick_i   (tq_tick),
      .fall_i   (fall),
      .prop_i   (cfg_q[OFS_PROP +: SEG_W]),
      .ph1_i    (cfg_q[OFS_PH1 +: SEG_W]),
      .ph2_i    (cfg_q[OFS_PH2 +: SEG_W]),
      .rjw_i    (cfg_q[OFS_RJW +: RJW_W]),
      .seg_o    (seg_w),
      .sample_o (sample_stb),
      .bit_o    (bit_stb)
   );

   assign seg = seg_w;

   AST_HSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      hard_sync |=> (seg == 2'd0)); // R10

   AST_CFG_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |=> (seg == 2'd0)); // R11

endmodule

// File: tb/test_cbt_sequencer.sv
module test_cbt_sequencer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode = 1'b1;
   logic [18:0] cfg_word = '0;
   logic        rx = 1'b1;
   logic        hard_sync = 1'b0;
   logic        tq_tick, sample_stb, bit_stb;
   logic [1:0]  seg;

   int n_run = 0;
   int n_fail = 0;
   int stray;
   int samp_cnt;
   logic [1:0] seg_log [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   cbt_sequencer i_cbt_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_mode   (cfg_mode),
      .cfg_word   (cfg_word),
      .rx         (rx),
      .hard_sync  (hard_sync),
      .tq_tick    (tq_tick),
      .sample_stb (sample_stb),
      .bit_stb    (bit_stb),
      .seg        (seg)
   );

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [18:0] mk(int p, int a, int b, int c, int j);
      return {j[1:0], c[2:0], b[2:0], a[2:0], p[7:0]};
   endfunction

   task automatic configure(logic [18:0] w);
      @(posedge clk); #1;
      cfg_mode = 1'b1; cfg_word = w; rx = 1'b1;
      repeat (3) @(posedge clk);
      #1 cfg_mode = 1'b0;
   endtask

   // Observes one bit; edge_q >= 0 drops rx inside that quantum index.
   task automatic next_bit(input int edge_q, output int s_at, output int len,
                           output int first_cyc);
      int j = 0;
      int k = 0;
      bit restore = 0;
      bit inject = 0;
      s_at = -1; len = -1; first_cyc = -1; stray = 0; samp_cnt = 0;
      if (edge_q == 0) begin
         @(posedge clk); #1 rx = 1'b0; restore = 1;
      end
      while (k < 20000) begin
         @(negedge clk); k++;
         if ((sample_stb || bit_stb) && !tq_tick) stray++;
         if (tq_tick) begin
            if (first_cyc < 0) first_cyc = k;
            if (j < 64) seg_log[j] = seg;
            if (sample_stb) begin s_at = j; samp_cnt++; end
            if (bit_stb) begin len = j + 1; break; end
            if (j == edge_q - 1) inject = 1;
            j++;
         end
         if (restore) begin
            @(posedge clk); #1 rx = 1'b1; restore = 0;
         end else if (inject) begin
            @(posedge clk); #1 rx = 1'b0; inject = 0; restore = 1;
         end
      end
      if (restore) begin
         @(posedge clk); #1 rx = 1'b1;
      end
   endtask

   task automatic t_reset();
      chk("R12 tick after reset", int'(tq_tick), 0);
      chk("R12 strobes after reset", int'(sample_stb | bit_stb), 0);
      chk("R12 seg after reset", int'(seg), 0);
   endtask

   task automatic t_basic();
      int s, l, f;
      configure(mk(3, 1, 2, 3, 1));
      next_bit(-1, s, l, f);
      chk("R1 first tick P=3", f, 4);
      chk("R3 sample index", s, 5);
      chk("R3 one sample per bit", samp_cnt, 1);
      chk("R2 bit length", l, 10);
      chk("R4 strobes only on ticks", stray, 0);
      chk("R6 seg q0", int'(seg_log[0]), 0);
      chk("R6 seg q2", int'(seg_log[2]), 1);
      chk("R6 seg q3", int'(seg_log[3]), 2);
      chk("R6 seg q5", int'(seg_log[5]), 2);
      chk("R6 seg q6", int'(seg_log[6]), 3);
      chk("R6 seg q9", int'(seg_log[9]), 3);
      next_bit(-1, s, l, f);
      chk("R1 tick period P=3", f, 4);
      chk("R4 back-to-back bit length", l, 10);
   endtask

   task automatic t_min_ph2();
      int s, l, f;
      configure(mk(0, 0, 0, 0, 0));
      next_bit(-1, s, l, f);
      chk("R1 first tick P=0", f, 1);
      chk("R5 ph2 code 0 bit length", l, 5);
      chk("R5 ph2 code 0 sample index", s, 2);
   endtask

   task automatic t_max_presc();
      int s, l, f;
      configure(mk(255, 0, 0, 1, 0));
      next_bit(-1, s, l, f);
      chk("R1 first tick P=255", f, 256);
      next_bit(-1, s, l, f);
      chk("R1 tick period P=255", f, 256);
      chk("R2 short bit length", l, 5);
   endtask

   task automatic t_max_segs();
      int s, l, f;
      configure(mk(0, 7, 7, 7, 0));
      next_bit(-1, s, l, f);
      chk("R2 max bit length", l, 25);
      chk("R3 max sample index", s, 16);
   endtask

   task automatic t_resync();
      int s, l, f;
      configure(mk(3, 1, 2, 3, 1));
      next_bit(3, s, l, f);
      chk("R7 late edge sample", s, 7);
      chk("R7 late edge length", l, 12);
      next_bit(-1, s, l, f);
      chk("R8 correction cleared next bit", l, 10);
      next_bit(2, s, l, f);
      chk("R7 error-limited length", l, 11);
      next_bit(1, s, l, f);
      chk("R7 zero error length", l, 10);
      next_bit(7, s, l, f);
      chk("R8 early edge length", l, 8);
      chk("R8 early edge sample", s, 5);
      next_bit(0, s, l, f);
      chk("R9 sync edge ignored", l, 10);
      configure(mk(3, 1, 2, 3, 3));
      next_bit(-1, s, l, f);
      next_bit(4, s, l, f);
      chk("R7 jump width 3 length", l, 13);
      chk("R7 jump width 3 sample", s, 8);
      next_bit(6, s, l, f);
      chk("R8 jump width 3 length", l, 7);
   endtask

   task automatic t_hsync();
      int s, l, f;
      configure(mk(3, 1, 2, 3, 1));
      repeat (13) @(posedge clk);
      #1 hard_sync = 1'b1;
      @(posedge clk); #1 hard_sync = 1'b0;
      chk("R10 seg after hard sync", int'(seg), 0);
      next_bit(-1, s, l, f);
      chk("R10 first tick after hard sync", f, 4);
      chk("R10 sample after hard sync", s, 5);
      chk("R10 bit after hard sync", l, 10);
   endtask

   task automatic t_cfg();
      int s, l, f;
      int ticks = 0;
      int strb = 0;
      configure(mk(3, 1, 2, 3, 1));
      @(posedge clk); #1 cfg_mode = 1'b1;
      repeat (8) begin
         @(negedge clk);
         if (tq_tick) ticks++;
         if (sample_stb || bit_stb) strb++;
      end
      chk("R11 no tick in config", ticks, 0);
      chk("R11 no strobe in config", strb, 0);
      chk("R11 seg parked in config", int'(seg), 0);
      @(posedge clk); #1 cfg_mode = 1'b0;
      next_bit(-1, s, l, f);
      @(posedge clk); #1 cfg_word = mk(0, 0, 0, 1, 0);
      next_bit(-1, s, l, f);
      chk("R11 word ignored tick period", f, 4);
      chk("R11 word ignored bit length", l, 10);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_min_ph2();
      t_max_presc();
      t_max_segs();
      t_resync();
      t_hsync();
      t_cfg();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule